// File: doc/BRIEF.md
# Condition Register Update Unit

This block owns a 32-bit condition register built from eight 4-bit fields and applies one update operation to it per clock. It handles four kinds of update: an integer compare that writes a 4-bit result into one field, a single-bit boolean operation that combines two register bits into a third, a copy of one field into another, and a masked write that loads selected fields from a 32-bit operand.

An execution pipeline presents an operation code, the operands, the indices and the mask with a valid strobe. The register takes the new value on the next rising clock edge and drives it on `cr_out`. Field and bit indices count from the most significant end of the register. The masked-write mask is the exception: it counts fields from the least significant end.

Top module: `cr_update_unit`

## Requirements
- R1: While `rst_n` is low the register is cleared, and `cr_out` reads 0 after reset.
- R2: A compare (`op_code` 0) writes a field of the form {LT,GT,EQ,SO} (LT=8, GT=4, EQ=2, SO=1). Exactly one of LT, GT and EQ is set, and SO is a copy of `so_in`. Field index f occupies bits 31-4f down to 28-4f. The other seven fields are unchanged.
- R3: With `cmp_signed` high both operands compare as two's complement values. With it low they compare as unsigned values.
- R4: Bit operations take codes 1 AND, 2 OR, 3 NAND, 4 XOR, 5 NOR, 6 equivalence, 7 A AND NOT B, and 8 A OR NOT B. Each reads bits A and B and writes bit T, where index i addresses register bit 31-i. No other bit changes.
- R5: A field move (`op_code` 9) copies the field at index `fld_src` into the field at index `fld_dst`. Both use the same MSB-first field numbering, and all other fields are unchanged.
- R6: A masked write (`op_code` 10) loads bits 4i+3..4i from `opnd_a` wherever `fld_mask[i]` is 1. Bits whose mask bit is 0 keep their value.
- R7: The register changes only on the rising edge that samples `op_valid` high. Without `op_valid` it holds its value, whatever the other inputs do.
- R8: Operation codes 11 to 15 leave the register unchanged even when `op_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First compare operand; source for masked write |
| opnd_b | input | 32 | Second compare operand |
| cmp_signed | input | 1 | 1 selects a signed compare, 0 an unsigned one |
| fld_dst | input | 3 | Destination field index for compare and move |
| fld_src | input | 3 | Source field index for move |
| bit_t | input | 5 | Target bit index for bit operations |
| bit_a | input | 5 | First source bit index |
| bit_b | input | 5 | Second source bit index |
| fld_mask | input | 8 | Field select for masked write |
| so_in | input | 1 | Summary-overflow bit copied into compare results |
| cr_out | output | 32 | Current register value |

## Verification
Compares use operand pairs whose sign bits differ, so that the signed and unsigned forms give opposite LT/GT answers. Equal operands check EQ, and `so_in` is toggled to check the SO copy. The bit operations are applied to register states that hold all four A/B combinations, and the first and last index positions are used to catch a numbering reversed against the MSB-first convention. Masked writes are run with empty, full and end-only masks against a register full of nonzero data. Idle cycles and unused codes are driven with aggressive operands to show that nothing moves.

// File: rtl/cr_update_unit.sv
module cr_update_unit #(
  parameter int FIELDS = 8,
  parameter int FW     = 4,
  localparam int W     = FIELDS * FW,
  localparam int FIDX  = $clog2(FIELDS),
  localparam int BIDX  = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      op_code,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic            cmp_signed,
  input  logic [FIDX-1:0] fld_dst,
  input  logic [FIDX-1:0] fld_src,
  input  logic [BIDX-1:0] bit_t,
  input  logic [BIDX-1:0] bit_a,
  input  logic [BIDX-1:0] bit_b,
  input  logic [FIELDS-1:0] fld_mask,
  input  logic            so_in,
  output logic [W-1:0]    cr_out
);
  localparam logic [3:0] OP_CMP  = 4'd0;
  localparam logic [3:0] OP_AND  = 4'd1;
  localparam logic [3:0] OP_OR   = 4'd2;
  localparam logic [3:0] OP_NAND = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_NOR  = 4'd5;
  localparam logic [3:0] OP_EQV  = 4'd6;
  localparam logic [3:0] OP_ANDC = 4'd7;
  localparam logic [3:0] OP_ORC  = 4'd8;
  localparam logic [3:0] OP_MOVE = 4'd9;
  localparam logic [3:0] OP_MASK = 4'd10;

  localparam logic [BIDX-1:0] BTOP = BIDX'(W - 1);
  localparam logic [FIDX-1:0] FTOP = FIDX'(FIELDS - 1);

  logic [W-1:0]    cr_q, cr_d, mask_x;
  logic [FIDX-1:0] dst_pos, src_pos;
  logic [BIDX-1:0] t_pos, a_pos, b_pos;
  logic [FW-1:0]   src_nib, cmp_nib;
  logic            lt, eq, gt, va, vb, bres;

  assign dst_pos = FTOP - fld_dst;
  assign src_pos = FTOP - fld_src;
  assign t_pos   = BTOP - bit_t;
  assign a_pos   = BTOP - bit_a;
  assign b_pos   = BTOP - bit_b;

  assign eq = (opnd_a == opnd_b);
  assign lt = cmp_signed ? ($signed(opnd_a) < $signed(opnd_b)) : (opnd_a < opnd_b);
  assign gt = !lt && !eq;
  assign cmp_nib = FW'({lt, gt, eq, so_in});

  assign va = cr_q[a_pos];
  assign vb = cr_q[b_pos];

  always_comb begin
    case (op_code)
      OP_AND:  bres = va & vb;
      OP_OR:   bres = va | vb;
      OP_NAND: bres = ~(va & vb);
      OP_XOR:  bres = va ^ vb;
      OP_NOR:  bres = ~(va | vb);
      OP_EQV:  bres = ~(va ^ vb);
      OP_ANDC: bres = va & ~vb;
      OP_ORC:  bres = va | ~vb;
      default: bres = 1'b0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < FIELDS; g++) begin : g_mask
      assign mask_x[g*FW +: FW] = {FW{fld_mask[g]}};
    end
  endgenerate

  always_comb begin
    src_nib = '0;
    for (int i = 0; i < FIELDS; i++)
      if (FIDX'(i) == src_pos) src_nib = cr_q[i*FW +: FW];
  end

  always_comb begin
    cr_d = cr_q;
    if (op_valid) begin
      case (op_code)
        OP_CMP: begin
          for (int i = 0; i < FIELDS; i++)
            if (FIDX'(i) == dst_pos) cr_d[i*FW +: FW] = cmp_nib;
        end
        OP_AND, OP_OR, OP_NAND, OP_XOR, OP_NOR, OP_EQV, OP_ANDC, OP_ORC: begin
          for (int j = 0; j < W; j++)
            if (BIDX'(j) == t_pos) cr_d[j] = bres;
        end
        OP_MOVE: begin
          for (int i = 0; i < FIELDS; i++)
            if (FIDX'(i) == dst_pos) cr_d[i*FW +: FW] = src_nib;
        end
        OP_MASK: cr_d = (opnd_a & mask_x) | (cr_q & ~mask_x);
        default: cr_d = cr_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cr_q <= '0;
    else        cr_q <= cr_d;
  end

  assign cr_out = cr_q;
endmodule

// File: rtl/cr_update_unit_chk.sv
module cr_update_unit_chk #(
  parameter int FIELDS = 8,
  parameter int FW     = 4,
  localparam int W     = FIELDS * FW,
  localparam int FIDX  = $clog2(FIELDS),
  localparam int BIDX  = $clog2(W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [W-1:0]      opnd_a,
  input logic [FIDX-1:0]   fld_dst,
  input logic [BIDX-1:0]   bit_t,
  input logic [FIELDS-1:0] fld_mask,
  input logic              so_in,
  input logic [W-1:0]      cr_out
);
  logic [FIDX-1:0]   dst_q;
  logic [BIDX-1:0]   t_q;
  logic [FIELDS-1:0] mask_q;
  logic [W-1:0]      dst_bits, t_bits, mask_bits;
  logic [FW-1:0]     dst_nib;

  always_ff @(posedge clk) begin
    dst_q  <= fld_dst;
    t_q    <= bit_t;
    mask_q <= fld_mask;
  end

  always_comb begin
    dst_bits = '0;
    dst_nib  = '0;
    for (int i = 0; i < FIELDS; i++)
      if (FIDX'(FIELDS - 1 - i) == dst_q) begin
        dst_bits[i*FW +: FW] = '1;
        dst_nib = cr_out[i*FW +: FW];
      end
    t_bits = '0;
    for (int j = 0; j < W; j++)
      if (BIDX'(W - 1 - j) == t_q) t_bits[j] = 1'b1;
    for (int i = 0; i < FIELDS; i++)
      mask_bits[i*FW +: FW] = {FW{mask_q[i]}};
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(cr_out)); // R7

  AST_CMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd0) |=> ($countones(dst_nib[FW-1:1]) == 1 && dst_nib[0] == $past(so_in))); // R2

  AST_CMP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd0 || op_code == 4'd9)) |=> (((cr_out ^ $past(cr_out)) & ~dst_bits) == '0)); // R5

  AST_BIT_ONLY_T: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'd1 && op_code <= 4'd8) |=> (((cr_out ^ $past(cr_out)) & ~t_bits) == '0)); // R4

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd10) |=> (((cr_out ^ $past(opnd_a)) & mask_bits) == '0
                                    && ((cr_out ^ $past(cr_out)) & ~mask_bits) == '0)); // R6

  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 4'd10) |=> $stable(cr_out)); // R8
endmodule

bind cr_update_unit cr_update_unit_chk #(.FIELDS(FIELDS), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .opnd_a(opnd_a), .fld_dst(fld_dst), .bit_t(bit_t), .fld_mask(fld_mask),
  .so_in(so_in), .cr_out(cr_out)
);

// File: tb/cr_update_unit_bench.sv
module cr_update_unit_bench;
  logic        clk = 0, rst_n = 0, op_valid = 0, cmp_signed = 0, so_in = 0;
  logic [3:0]  op_code = 0;
  logic [31:0] opnd_a = 0, opnd_b = 0;
  logic [2:0]  fld_dst = 0, fld_src = 0;
  logic [4:0]  bit_t = 0, bit_a = 0, bit_b = 0;
  logic [7:0]  fld_mask = 0;
  logic [31:0] cr_out;
  logic [31:0] model;
  int checks = 0, fails = 0;
  bit done = 0;

  cr_update_unit u_cr_update_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cmp_signed(cmp_signed),
    .fld_dst(fld_dst), .fld_src(fld_src), .bit_t(bit_t), .bit_a(bit_a),
    .bit_b(bit_b), .fld_mask(fld_mask), .so_in(so_in), .cr_out(cr_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] code);
    @(negedge clk);
    op_code = code; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic set_field(input int f, input logic [3:0] v);
    model[31-4*f -: 4] = v;
  endtask

  task automatic t_reset;
    chk("R1 reset", cr_out, 32'h0);
    model = 0;
  endtask

  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input bit sgn,
                        input bit so, input int f, input string req);
    logic lt, eq;
    opnd_a = a; opnd_b = b; cmp_signed = sgn; so_in = so; fld_dst = 3'(f);
    eq = (a == b);
    lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    set_field(f, {lt, !lt && !eq, eq, so});
    issue(4'd0);
    chk(req, cr_out, model);
  endtask

  task automatic t_compare;
    do_cmp(32'hFFFF_FFFE, 32'h0000_0005, 1, 0, 0, "R2 R3 signed lt field0");
    do_cmp(32'hFFFF_FFFE, 32'h0000_0005, 0, 1, 7, "R2 R3 unsigned gt field7 so");
    do_cmp(32'h1234_5678, 32'h1234_5678, 1, 1, 3, "R2 equal field3");
    do_cmp(32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 5, "R3 unsigned msb gt");
    do_cmp(32'h8000_0000, 32'h7FFF_FFFF, 1, 0, 5, "R3 signed msb lt");
  endtask

  task automatic do_bit(input logic [3:0] code, input int t, input int a, input int b, input string req);
    logic va, vb, r;
    bit_t = 5'(t); bit_a = 5'(a); bit_b = 5'(b);
    va = model[31-a]; vb = model[31-b];
    case (code)
      4'd1: r = va & vb;
      4'd2: r = va | vb;
      4'd3: r = ~(va & vb);
      4'd4: r = va ^ vb;
      4'd5: r = ~(va | vb);
      4'd6: r = ~(va ^ vb);
      4'd7: r = va & ~vb;
      default: r = va | ~vb;
    endcase
    model[31-t] = r;
    issue(code);
    chk(req, cr_out, model);
  endtask

  task automatic t_bitlogic;
    opnd_a = 32'hA5C3_0F96; fld_mask = 8'hFF;
    model = opnd_a;
    issue(4'd10);
    chk("R6 preload", cr_out, model);
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 1; c <= 8; c++) begin
        do_bit(4'(c), (c * 7 + pass * 11) % 32, pass ? 31 : 0, (c * 5) % 32, "R4 bit op");
      end
    end
    do_bit(4'd5, 31, 0, 31, "R4 nor edge indices");
    do_bit(4'd8, 0, 31, 0, "R4 orc edge indices");
  endtask

  task automatic t_move;
    logic [3:0] v;
    fld_src = 3'd1; fld_dst = 3'd6;
    v = model[31-4*1 -: 4];
    set_field(6, v);
    issue(4'd9);
    chk("R5 move 1->6", cr_out, model);
    fld_src = 3'd7; fld_dst = 3'd0;
    v = model[3:0];
    set_field(0, v);
    issue(4'd9);
    chk("R5 move 7->0", cr_out, model);
  endtask

  task automatic do_mask(input logic [31:0] d, input logic [7:0] m, input string req);
    logic [31:0] x;
    for (int i = 0; i < 8; i++) x[4*i +: 4] = {4{m[i]}};
    opnd_a = d; fld_mask = m;
    model = (d & x) | (model & ~x);
    issue(4'd10);
    chk(req, cr_out, model);
  endtask

  task automatic t_maskwrite;
    do_mask(32'h1357_9BDF, 8'hFF, "R6 full mask");
    do_mask(32'hFFFF_FFFF, 8'h00, "R6 empty mask");
    do_mask(32'hE000_000E, 8'h81, "R6 end fields");
    do_mask(32'h0F0F_0F0F, 8'h5A, "R6 mixed mask");
  endtask

  task automatic t_hold;
    opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h0; fld_mask = 8'hFF; fld_dst = 3'd2;
    op_code = 4'd10; op_valid = 0;
    repeat (3) @(negedge clk);
    chk("R7 idle hold", cr_out, model);
    for (int c = 11; c <= 15; c++) begin
      issue(4'(c));
      chk("R8 unused code", cr_out, model);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_compare();
    t_bitlogic();
    t_move();
    t_maskwrite();
    t_hold();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule